// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block produces a reference clock from one of three selectable sources. Each source arrives as a tick stream, a clock-enable pulse on the single system clock. The block divides the selected stream by a ratio made of a 15-bit integer part and a 9-bit trim fraction in 1/512 steps, so the output frequency is the source frequency divided by 2 × (div + trim/512). A phase accumulator spreads the fraction over the half-periods. Each carry out of the accumulator adds one source tick to the half-period in which it occurs.

Software writes the settings through two 32-bit registers. The control register holds the source code, divider, output enable, run enable and switch-request bit, plus a read-only running flag. The trim register holds the fraction. Each register has a plain-write address, a clear alias and a set alias. A new divider and trim are pending until software raises the switch-request bit. The hardware then applies them at a half-period boundary, or at once when the output is stopped, and clears the bit. Clearing the run enable lets the output finish its high phase, then holds it low.

Top module: `refdiv_top`

## Requirements
- R1: After reset the control and trim registers read 0x00000000, ref_out is low and the running flag (control bit 8) reads 0.
- R2: A write to address 0x00 replaces the control register and a write to 0x10 replaces the trim register. Control fields: source code 3:0, switch request 9, output enable 12, run enable 15, divider 30:16. Trim: bits 31:23. Every other bit reads 0, bit 8 ignores writes, and writes to addresses other than 0x00, 0x04, 0x08, 0x10, 0x14 and 0x18 change nothing.
- R3: A write to the clear alias (base + 0x04) clears the bits that are 1 in the data. A write to the set alias (base + 0x08) sets them. All other bits of that register keep their values.
- R4: Writing the divider or trim field changes nothing at the output until a switch request is made.
- R5: Writing 1 to bit 9 copies the pending divider and trim into the active divider. If the output is stopped, the bit reads 1 for one cycle and reads 0 after the next clock edge. If the output is running, the copy and the clear happen at the end of the current half-period, and the next half-period uses the new values.
- R6: With divider D ≥ 1 and trim T, half-period k (k = 0 at start or after a switch) lasts D + floor((k+1)·T/512) − floor(k·T/512) source ticks. The output starts low.
- R7: With an active divider of 0, ref_out equals the selected tick as sampled at the previous clock edge.
- R8: Source code 0 selects sys_tick, code 7 selects pll_tick and code 8 selects ext_tick. Every other code supplies no ticks, so ref_out stays where it is.
- R9: With output enable at 0, ref_out is low from the second clock edge onward while the divider keeps running and bit 8 keeps reading 1.
- R10: Bit 8 reads 1 while the divider runs. After run enable is cleared during a high phase, that high phase completes at its full length, ref_out then stays low, and bit 8 reads 0 from the second edge after the fall.
- R11: If the switch completes in the same cycle as a control write, bit 9 stays 1 when that write sets it (plain write or set alias with data bit 9 = 1), and a second switch loads the newer values one cycle later. Any other write in that cycle leaves bit 9 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte address (any alias of a register) |
| rd_data | output | 32 | Read data, combinational |
| sys_tick | input | 1 | System clock tick stream (code 0) |
| pll_tick | input | 1 | PLL tick stream (code 7) |
| ext_tick | input | 1 | External reference tick stream (code 8) |
| ref_out | output | 1 | Divided reference clock |

## Verification
Two things can land in one cycle: a software write to the control register, and the hardware completing a switch request and clearing bit 9. The bench provokes this with the output stopped. It issues a switching write and then a second control write on the very next edge, which is the edge where the first switch completes. When the second write sets bit 9 again, bit 9 must still read 1 and the half-periods that follow must show the second divider, not the first. When the second write only sets the output enable, bit 9 must read 0 right after that edge.

// File: rtl/refdiv_pkg.sv
`timescale 1ns/1ps
package refdiv_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int SEL_W    = 4;
    localparam int DIV_W    = 15;
    localparam int TRIM_W   = 9;

    // bit positions software depends on
    localparam int SEL_LSB  = 0;
    localparam int ACT_BIT  = 8;
    localparam int SW_BIT   = 9;
    localparam int OE_BIT   = 12;
    localparam int ON_BIT   = 15;
    localparam int DIV_LSB  = 16;
    localparam int TRIM_LSB = 23;

    // address layout: bank in bit 4, operation in bits 3:2
    localparam int BANK_LSB = 4;

    localparam logic [SEL_W-1:0] SRC_SYS = 4'd0;
    localparam logic [SEL_W-1:0] SRC_PLL = 4'd7;
    localparam logic [SEL_W-1:0] SRC_EXT = 4'd8;

    typedef enum logic [1:0] {
        WOP_NONE,
        WOP_PLAIN,
        WOP_CLR,
        WOP_SET
    } wop_e;

    function automatic logic [DATA_W-1:0] merge_word(
        input wop_e              op,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd
    );
        case (op)
            WOP_PLAIN: merge_word = wd;
            WOP_CLR:   merge_word = cur & ~wd;
            WOP_SET:   merge_word = cur | wd;
            default:   merge_word = cur;
        endcase
    endfunction
endpackage

// File: rtl/refdiv_regs.sv
`timescale 1ns/1ps
module refdiv_regs
    import refdiv_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = SEL_W,
    parameter int NW = DIV_W,
    parameter int TW = TRIM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          active,
    input  logic          sw_done,
    output logic [SW-1:0] sel,
    output logic          sw_req,
    output logic          oe,
    output logic          run_en,
    output logic [NW-1:0] div_pend,
    output logic [TW-1:0] trim_pend
);
    localparam int BANK_W = AW - BANK_LSB;

    typedef struct packed {
        logic [SW-1:0] sel;
        logic          sw;
        logic          oe;
        logic          on;
        logic [NW-1:0] div;
        logic [TW-1:0] trim;
    } regs_t;

    regs_t regs_d, regs_q;

    wop_e              op;
    logic [BANK_W-1:0] wr_bank;
    logic [BANK_W-1:0] rd_bank;
    logic              rd_ok;
    logic [DW-1:0]     ctrl_img, trim_img, ctrl_w, trim_w;
    logic              set_sw;
    logic              unused_word;

    always_comb begin
        wr_bank = wr_addr[AW-1:BANK_LSB];
        rd_bank = rd_addr[AW-1:BANK_LSB];
        op = WOP_NONE;
        if (wr_en && wr_addr[1:0] == 2'b00 && wr_bank <= BANK_W'(1)) begin
            case (wr_addr[3:2])
                2'b00:   op = WOP_PLAIN;
                2'b01:   op = WOP_CLR;
                2'b10:   op = WOP_SET;
                default: op = WOP_NONE;
            endcase
        end
        rd_ok = (rd_addr[1:0] == 2'b00) && (rd_addr[3:2] != 2'b11);

        ctrl_img = '0;
        ctrl_img[SEL_LSB +: SW] = regs_q.sel;
        ctrl_img[ACT_BIT]       = active;
        ctrl_img[SW_BIT]        = regs_q.sw;
        ctrl_img[OE_BIT]        = regs_q.oe;
        ctrl_img[ON_BIT]        = regs_q.on;
        ctrl_img[DIV_LSB +: NW] = regs_q.div;
        trim_img = '0;
        trim_img[TRIM_LSB +: TW] = regs_q.trim;

        ctrl_w = merge_word(op, ctrl_img, wr_data);
        trim_w = merge_word(op, trim_img, wr_data);

        regs_d = regs_q;
        set_sw = 1'b0;
        if (op != WOP_NONE && wr_bank == BANK_W'(0)) begin
            regs_d.sel = ctrl_w[SEL_LSB +: SW];
            regs_d.sw  = ctrl_w[SW_BIT];
            regs_d.oe  = ctrl_w[OE_BIT];
            regs_d.on  = ctrl_w[ON_BIT];
            regs_d.div = ctrl_w[DIV_LSB +: NW];
            set_sw     = (op == WOP_PLAIN || op == WOP_SET) && wr_data[SW_BIT];
        end
        if (op != WOP_NONE && wr_bank == BANK_W'(1)) begin
            regs_d.trim = trim_w[TRIM_LSB +: TW];
        end
        // completion clears the request unless this cycle's write re-arms it
        if (sw_done) begin
            regs_d.sw = set_sw;
        end

        if (!rd_ok)                        rd_data = '0;
        else if (rd_bank == BANK_W'(0))    rd_data = ctrl_img;
        else if (rd_bank == BANK_W'(1))    rd_data = trim_img;
        else                               rd_data = '0;
    end

    assign unused_word = ^{ctrl_w, trim_w};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign sel       = regs_q.sel;
    assign sw_req    = regs_q.sw;
    assign oe        = regs_q.oe;
    assign run_en    = regs_q.on;
    assign div_pend  = regs_q.div;
    assign trim_pend = regs_q.trim;

    AST_SW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done && !set_sw |=> !sw_req); // R5
    AST_SW_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        sw_done && set_sw |=> sw_req); // R11
    AST_SW_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_req && !wr_en |=> !sw_req); // R5
endmodule

// File: rtl/refdiv_srcmux.sv
`timescale 1ns/1ps
module refdiv_srcmux
    import refdiv_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic [SW-1:0] sel,
    input  logic          sys_tick,
    input  logic          pll_tick,
    input  logic          ext_tick,
    output logic          tick
);
    always_comb begin
        case (sel)
            SRC_SYS: tick = sys_tick;
            SRC_PLL: tick = pll_tick;
            SRC_EXT: tick = ext_tick;
            default: tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/refdiv_core.sv
`timescale 1ns/1ps
module refdiv_core
    import refdiv_pkg::*;
#(
    parameter int NW = DIV_W,
    parameter int TW = TRIM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run_en,
    input  logic          oe,
    input  logic          sw_req,
    input  logic [NW-1:0] div_pend,
    input  logic [TW-1:0] trim_pend,
    output logic          sw_done,
    output logic          active,
    output logic          ref_out
);
    localparam int CNT_W = NW + 1;

    typedef struct packed {
        logic             run;
        logic             phase;
        logic             ref_o;
        logic [CNT_W-1:0] cnt;
        logic [TW-1:0]    acc;
        logic [NW-1:0]    div;
        logic [TW-1:0]    trim;
    } core_t;

    core_t core_d, core_q;

    logic [TW:0]      sum;
    logic [CNT_W-1:0] half_len;
    logic             bypass;
    logic             half_end;

    always_comb begin
        sum      = {1'b0, core_q.acc} + {1'b0, core_q.trim};
        half_len = CNT_W'(core_q.div) + CNT_W'(sum[TW]);
        bypass   = (core_q.div == '0);
        half_end = core_q.run && tick && !bypass
                   && ((core_q.cnt + CNT_W'(1)) >= half_len);
        sw_done  = sw_req && (!core_q.run || bypass || half_end);

        core_d = core_q;
        if (!core_q.run) begin
            core_d.phase = 1'b0;
            core_d.cnt   = '0;
            core_d.acc   = '0;
            core_d.run   = run_en;
        end else if (!run_en && !core_q.phase) begin
            core_d.run = 1'b0;
        end else if (bypass) begin
            core_d.phase = tick;
        end else if (tick) begin
            if (half_end) begin
                core_d.phase = ~core_q.phase;
                core_d.cnt   = '0;
                core_d.acc   = sum[TW-1:0];
            end else begin
                core_d.cnt = core_q.cnt + CNT_W'(1);
            end
        end

        if (sw_done) begin
            core_d.div  = div_pend;
            core_d.trim = trim_pend;
            core_d.acc  = '0;
            core_d.cnt  = '0;
        end

        core_d.ref_o = core_d.phase & oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign active  = core_q.run;
    assign ref_out = core_q.ref_o;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !core_q.run |=> !ref_out); // R10
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> !ref_out); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.run && !bypass |-> core_q.cnt < half_len); // R6
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.run && !bypass && !tick |=> $stable(core_q.phase)); // R8
endmodule

// File: rtl/refdiv_top.sv
`timescale 1ns/1ps
module refdiv_top
    import refdiv_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          sys_tick,
    input  logic          pll_tick,
    input  logic          ext_tick,
    output logic          ref_out
);
    logic [SEL_W-1:0]  sel;
    logic              sw_req, sw_done, oe, run_en, active, tick;
    logic [DIV_W-1:0]  div_pend;
    logic [TRIM_W-1:0] trim_pend;

    refdiv_regs #(.AW(AW), .DW(DW), .SW(SEL_W), .NW(DIV_W), .TW(TRIM_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .active    (active),
        .sw_done   (sw_done),
        .sel       (sel),
        .sw_req    (sw_req),
        .oe        (oe),
        .run_en    (run_en),
        .div_pend  (div_pend),
        .trim_pend (trim_pend)
    );

    refdiv_srcmux #(.SW(SEL_W)) u_mux (
        .sel      (sel),
        .sys_tick (sys_tick),
        .pll_tick (pll_tick),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    refdiv_core #(.NW(DIV_W), .TW(TRIM_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run_en    (run_en),
        .oe        (oe),
        .sw_req    (sw_req),
        .div_pend  (div_pend),
        .trim_pend (trim_pend),
        .sw_done   (sw_done),
        .active    (active),
        .ref_out   (ref_out)
    );
endmodule

// File: tb/refdiv_top_tb.sv
`timescale 1ns/1ps
module refdiv_top_tb;
    localparam logic [4:0] A_CTRL = 5'h00, A_CCLR = 5'h04, A_CSET = 5'h08;
    localparam logic [4:0] A_TRIM = 5'h10, A_TCLR = 5'h14, A_TSET = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sys_tick = 1'b0, pll_tick = 1'b0, ext_tick = 1'b0;
    logic        ref_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    refdiv_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_tick(sys_tick), .pll_tick(pll_tick), .ext_tick(ext_tick),
        .ref_out(ref_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        rd_addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic stop_wait();
        logic [31:0] v;
        wr(A_CCLR, 32'h8000);
        for (int i = 0; i < 200; i++) begin
            rd(A_CTRL, v);
            if (!v[8]) break;
            step(1);
        end
    endtask

    // aligns on the next output edge, then times nh half-periods
    task automatic run_halves(input int dv, input int tv, input int nh,
                              output int nbad, output int fact, output int fexp);
        logic prev;
        int len, e;
        nbad = 0; fact = 0; fexp = 0;
        prev = ref_out; len = 0;
        while (ref_out == prev && len < 4 * dv + 64) begin step(1); len++; end
        for (int k = 1; k <= nh; k++) begin
            prev = ref_out; len = 0;
            e = dv + ((k + 1) * tv) / 512 - (k * tv) / 512;
            do begin step(1); len++; end while (ref_out == prev && len < 2 * dv + 8);
            if (len != e) begin
                if (nbad == 0) begin fact = len; fexp = e; end
                nbad++;
            end
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R1..all actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int nb, fa, fe, hi, cnt, mis;
        int dl[4] = '{1, 2, 3, 5};
        int tl[6] = '{0, 1, 77, 255, 256, 511};

        step(3);
        rst_n = 1'b1;
        sys_tick = 1'b1;
        step(1);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(A_TRIM, v); chk("R1 trim", v, 32'h0);
        chk("R1 ref_out", {31'd0, ref_out}, 32'h0);

        // R2 plain writes, read-only bit 8, unused bits
        wr(A_CTRL, 32'hDA5A11F3);
        rd(A_CTRL, v); chk("R2 ctrl plain", v, 32'h5A5A1003);
        wr(A_TRIM, 32'hFFFFFFFF);
        rd(A_TRIM, v); chk("R2 trim plain", v, 32'hFF800000);
        wr(5'h0C, 32'hFFFFFFFF);
        wr(5'h01, 32'hFFFFFFFF);
        rd(A_CTRL, v); chk("R2 ignored addresses", v, 32'h5A5A1003);
        rd(5'h08, v); chk("R2 read via alias", v, 32'h5A5A1003);

        // R3 aliases
        wr(A_CCLR, 32'h00001001);
        rd(A_CTRL, v); chk("R3 ctrl clear alias", v, 32'h5A5A0002);
        wr(A_CSET, 32'h00010004);
        rd(A_CTRL, v); chk("R3 ctrl set alias", v, 32'h5A5B0006);
        wr(A_TCLR, 32'h00800000);
        rd(A_TRIM, v); chk("R3 trim clear alias", v, 32'hFF000000);
        wr(A_TSET, 32'h00800000);
        rd(A_TRIM, v); chk("R3 trim set alias", v, 32'hFF800000);
        wr(A_CTRL, 32'h0);
        wr(A_TRIM, 32'h0);

        // R5 switch while stopped: one cycle high
        wr(A_CSET, 32'h200);
        rd(A_CTRL, v); chk("R5 sw set", {31'd0, v[9]}, 32'h1);
        step(1);
        rd(A_CTRL, v); chk("R5 sw auto-clear", {31'd0, v[9]}, 32'h0);

        // R11 completion coincides with a write that does not re-arm
        wr(A_CTRL, (32'd2 << 16) | 32'h200);
        wr(A_CSET, 32'h1000);
        rd(A_CTRL, v); chk("R11 other write, sw cleared", {31'd0, v[9]}, 32'h0);
        // R11 completion coincides with a re-arming write
        wr(A_CTRL, (32'd3 << 16) | 32'h200);
        wr(A_CTRL, (32'd6 << 16) | 32'h1200);
        rd(A_CTRL, v); chk("R11 re-armed sw", {31'd0, v[9]}, 32'h1);
        step(1);
        rd(A_CTRL, v); chk("R11 second switch done", {31'd0, v[9]}, 32'h0);
        wr(A_CSET, 32'h8000);
        run_halves(6, 0, 8, nb, fa, fe);
        chk("R11 newer divider in use", fa, fe);
        chk("R11 mismatched halves", nb, 0);

        // R4 pending divider has no effect
        wr(A_CTRL, (32'd4 << 16) | 32'h9000);
        run_halves(6, 0, 6, nb, fa, fe);
        chk("R4 old divider kept", nb, 0);

        // R5 switch while running
        wr(A_CSET, 32'h200);
        rd(A_CTRL, v); chk("R5 running sw set", {31'd0, v[9]}, 32'h1);
        cnt = 0;
        while (v[9] && cnt < 40) begin step(1); cnt++; rd(A_CTRL, v); end
        chk("R5 cleared within a half-period", {31'd0, cnt <= 6}, 32'h1);
        run_halves(4, 0, 6, nb, fa, fe);
        chk("R5 new divider after boundary", nb, 0);

        // R9 output enable gates ref_out only
        wr(A_CCLR, 32'h1000);
        step(1);
        hi = 0;
        for (int i = 0; i < 30; i++) begin step(1); hi += ref_out; end
        chk("R9 ref_out low with oe=0", hi, 0);
        rd(A_CTRL, v); chk("R9 still active", {31'd0, v[8]}, 32'h1);
        wr(A_CSET, 32'h1000);
        run_halves(4, 0, 4, nb, fa, fe);
        chk("R9 output resumes", nb, 0);

        // R10 stop during high phase
        cnt = 0;
        while (ref_out != 1'b0 && cnt < 20) begin step(1); cnt++; end
        while (ref_out != 1'b1 && cnt < 40) begin step(1); cnt++; end
        wr(A_CCLR, 32'h8000);
        rd(A_CTRL, v); chk("R10 active during high phase", {31'd0, v[8]}, 32'h1);
        hi = 1;
        while (ref_out == 1'b1 && hi < 20) begin step(1); hi++; end
        chk("R10 high phase full length", hi, 4);
        rd(A_CTRL, v); chk("R10 active at fall", {31'd0, v[8]}, 32'h1);
        step(1);
        rd(A_CTRL, v); chk("R10 inactive after fall", {31'd0, v[8]}, 32'h0);
        hi = 0;
        for (int i = 0; i < 20; i++) begin step(1); hi += ref_out; end
        chk("R10 held low", hi, 0);

        // R7 / R8 pass-through, sweep of every source code
        stop_wait();
        wr(A_CTRL, 32'h200);
        step(2);
        wr(A_CSET, 32'h9000);
        step(3);
        for (int code = 0; code < 16; code++) begin
            wr(A_CTRL, code | 32'h9000);
            mis = 0;
            for (int i = 0; i < 12; i++) begin
                logic s, p, x, e;
                @(negedge clk);
                s = (i % 2) == 1; p = (i % 3) == 0; x = (i % 4) >= 2;
                sys_tick = s; pll_tick = p; ext_tick = x;
                e = (code == 0) ? s : (code == 7) ? p : (code == 8) ? x : 1'b0;
                @(posedge clk); #1;
                if (ref_out !== e) mis++;
            end
            chk($sformatf("R8 R7 source code %0d", code), mis, 0);
        end
        sys_tick = 1'b1; pll_tick = 1'b0; ext_tick = 1'b0;

        // R6 sweep of divider and trim, 512 half-periods each
        foreach (dl[i]) begin
            foreach (tl[j]) begin
                stop_wait();
                wr(A_TRIM, tl[j] << 23);
                wr(A_CTRL, (dl[i] << 16) | 32'h1200);
                step(2);
                wr(A_CSET, 32'h8000);
                run_halves(dl[i], tl[j], 512, nb, fa, fe);
                total++;
                if (nb != 0) begin
                    bad++;
                    $display("FAIL R6 div=%0d trim=%0d bad halves=%0d actual=%0d expected=%0d",
                             dl[i], tl[j], nb, fa, fe);
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule